// File: doc/BRIEF.md
# PC Card Host Cycle Controller

This block turns word requests from a host into read and write cycles on a PC Card style slot bus. Each request names one of three card spaces: common memory, attribute memory or I/O. It also gives a start address and a word count. For reads, the host chooses whether the card address stays fixed or steps up by one for each word. The controller drives a strobe for every card word. The strobe width is either a programmed fixed number of clocks, or it is stretched by the card through a WAIT input and cut short by a timeout.

A read-ahead option helps streaming reads. When it is enabled, a completed eight-word incrementing read triggers a background fetch of the next eight words into a local buffer. A later host read that starts at that buffer's address, in the same space, is answered from the buffer with no card cycle. Writes, space changes and card removal throw the buffer away. Card removal also returns the space selection to common memory.

Top module: `pccard_cycle_ctrl`

## Requirements
- R1: After reset, req_ready is 1, card_strobe is 0, card_space is 0 (common), and rsp_valid and done are 0.
- R2: Space codes are 0 for common, 1 for attribute and 2 for I/O. Code 3 is treated as common. card_space carries the mapped code for every card cycle of a request.
- R3: With cfg_wait_mode at 0, each card strobe stays high for exactly cfg_fixed_len clocks. Values below 2 are treated as 2.
- R4: With cfg_wait_mode at 1, the strobe stays high for at least cfg_min_strobe clocks (0 is treated as 1). It ends in the first strobe clock at or after that minimum in which card_wait is low.
- R5: In WAIT mode, a strobe that is still held at its 255th clock is abandoned. That request ends with done and done_err both high.
- R6: A read of req_len+1 words returns one rsp_valid pulse per word, in order. Each word is taken from the card at req_addr+i when req_incr is 1, or at req_addr when it is 0. done pulses with the last word.
- R7: A write moves exactly one word. card_we is high during its strobe, card_wdata equals req_wdata, and done follows with done_err at 0.
- R8: With cfg_readahead at 1, an incrementing 8-word card read is followed by 8 further card reads. These start at the address after the last word read and fill the prefetch buffer.
- R9: A read with req_incr at 1, a space matching the buffer, and req_addr equal to the buffer start is served from a valid buffer without any card strobe.
- R10: Any write, any request in a space other than the current one, or card removal invalidates the prefetch buffer.
- R11: A card_removed pulse sets card_space to common. It also aborts a host transfer in progress, with done_err at 1.
- R12: req_ready is high only while idle, so only one request is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wait_mode | input | 1 | 0 fixed strobe, 1 card-stretched strobe |
| cfg_fixed_len | input | 4 | Fixed strobe width in clocks |
| cfg_min_strobe | input | 4 | Minimum strobe width before WAIT is honoured |
| cfg_readahead | input | 1 | Enable background fetch of the next 8 words |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_space | input | 2 | Card space code |
| req_addr | input | AW | Start card address |
| req_wdata | input | DW | Write data |
| req_len | input | 3 | Read word count minus one |
| req_incr | input | 1 | 1 incrementing address, 0 static |
| rsp_valid | output | 1 | Read word valid |
| rsp_data | output | DW | Read word |
| done | output | 1 | Request finished |
| done_err | output | 1 | Request ended by timeout or removal |
| card_removed | input | 1 | Card-removal event pulse |
| card_strobe | output | 1 | Card cycle strobe |
| card_we | output | 1 | Write cycle indicator |
| card_space | output | 2 | Space of the current cycle |
| card_addr | output | AW | Card address |
| card_wdata | output | DW | Card write data |
| card_rdata | input | DW | Card read data |
| card_wait | input | 1 | Card asks to extend the strobe |

## Verification
The assertions assume that the configuration inputs stay constant while a request is in flight. They also assume that card_removed arrives as an isolated pulse. The stimulus changes the configuration only after done, and only while req_ready is high. Removal is pulsed only when the controller is idle. The card model raises WAIT only inside a strobe, for a programmed number of its first clocks. It returns data computed from the space and address, so every returned word shows which cycle produced it.

// File: rtl/pccard_cycle_ctrl.sv
module pccard_cycle_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BUF_WORDS = 8,
  parameter int TIMEOUT = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wait_mode,
  input  logic [3:0]    cfg_fixed_len,
  input  logic [3:0]    cfg_min_strobe,
  input  logic          cfg_readahead,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_space,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [2:0]    req_len,
  input  logic          req_incr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          done,
  output logic          done_err,
  input  logic          card_removed,
  output logic          card_strobe,
  output logic          card_we,
  output logic [1:0]    card_space,
  output logic [AW-1:0] card_addr,
  output logic [DW-1:0] card_wdata,
  input  logic [DW-1:0] card_rdata,
  input  logic          card_wait
);
  localparam int IW = $clog2(BUF_WORDS);
  localparam int CW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_CYC, S_GAP, S_SERVE} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [AW-1:0] cur_addr, buf_base;
  logic [1:0]    space_q, buf_space;
  logic          we_q, incr_q, pf_q, ra_q, buf_ok;
  logic [DW-1:0] wdata_q;
  logic [IW:0]   left;
  logic [IW-1:0] idx;
  logic [DW-1:0] buf_mem [BUF_WORDS];

  wire [1:0] req_sp   = (req_space == 2'd3) ? 2'd0 : req_space;
  wire [3:0] eff_len  = (cfg_fixed_len < 4'd2) ? 4'd2 : cfg_fixed_len;
  wire [3:0] eff_min  = (cfg_min_strobe == 4'd0) ? 4'd1 : cfg_min_strobe;
  wire cyc_end = cfg_wait_mode ? (cnt >= CW'(eff_min) && !card_wait) : (cnt == CW'(eff_len));
  wire tmo     = cfg_wait_mode && !cyc_end && cnt == CW'(TIMEOUT);
  wire hit     = buf_ok && !req_write && req_incr && req_sp == buf_space && req_addr == buf_base;

  assign req_ready   = (st == S_IDLE) && !card_removed;
  assign card_strobe = (st == S_CYC);
  assign card_we     = we_q && card_strobe;
  assign card_space  = space_q;
  assign card_addr   = cur_addr;
  assign card_wdata  = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; cur_addr <= '0; buf_base <= '0;
      space_q <= 2'd0; buf_space <= 2'd0; we_q <= 1'b0; incr_q <= 1'b0;
      pf_q <= 1'b0; ra_q <= 1'b0; buf_ok <= 1'b0; wdata_q <= '0;
      left <= '0; idx <= '0; rsp_valid <= 1'b0; rsp_data <= '0;
      done <= 1'b0; done_err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0; done <= 1'b0; done_err <= 1'b0;
      if (card_removed) begin
        buf_ok <= 1'b0; space_q <= 2'd0; pf_q <= 1'b0; st <= S_IDLE;
        if (st != S_IDLE && !pf_q) begin done <= 1'b1; done_err <= 1'b1; end
      end else begin
        case (st)
          S_IDLE: if (req_valid) begin
            idx <= '0;
            if (hit) begin
              st <= S_SERVE; left <= (IW+1)'(req_len) + 1'b1;
            end else begin
              st <= S_CYC; cnt <= CW'(1);
              cur_addr <= req_addr; space_q <= req_sp; we_q <= req_write;
              wdata_q <= req_wdata; incr_q <= req_incr; pf_q <= 1'b0;
              left <= req_write ? (IW+1)'(1) : (IW+1)'(req_len) + 1'b1;
              ra_q <= cfg_readahead && !req_write && req_incr && req_len == 3'(BUF_WORDS-1);
              if (req_write || req_sp != space_q) buf_ok <= 1'b0;
            end
          end
          S_SERVE: begin
            rsp_valid <= 1'b1; rsp_data <= buf_mem[idx];
            idx <= idx + 1'b1; left <= left - 1'b1;
            if (left == (IW+1)'(1)) begin done <= 1'b1; st <= S_IDLE; end
          end
          S_CYC: if (cyc_end) begin
            if (pf_q) buf_mem[idx] <= card_rdata;
            else if (!we_q) begin rsp_valid <= 1'b1; rsp_data <= card_rdata; end
            idx <= idx + 1'b1;
            if (incr_q) cur_addr <= cur_addr + 1'b1;
            if (left == (IW+1)'(1)) begin
              if (pf_q) begin
                buf_ok <= 1'b1; pf_q <= 1'b0; st <= S_IDLE;
              end else begin
                done <= 1'b1;
                if (ra_q) begin
                  pf_q <= 1'b1; buf_ok <= 1'b0; buf_base <= cur_addr + 1'b1;
                  buf_space <= space_q; left <= (IW+1)'(BUF_WORDS); idx <= '0;
                  st <= S_GAP;
                end else st <= S_IDLE;
              end
            end else begin
              left <= left - 1'b1; st <= S_GAP;
            end
          end else if (tmo) begin
            st <= S_IDLE; buf_ok <= 1'b0;
            if (!pf_q) begin done <= 1'b1; done_err <= 1'b1; end
            pf_q <= 1'b0;
          end else cnt <= cnt + 1'b1;
          S_GAP: begin st <= S_CYC; cnt <= CW'(1); end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_space_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    card_strobe && $past(card_strobe) |-> $stable(card_space) && $stable(card_addr));
  p_fixed_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wait_mode && card_strobe |-> cnt <= CW'(eff_len));
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wait_mode && card_strobe && card_wait && !card_removed && cnt < CW'(TIMEOUT) |=> card_strobe);
  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_removal_common_r11: assert property (@(posedge clk) disable iff (!rst_n)
    card_removed |=> card_space == 2'd0);
  p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);
endmodule

// File: tb/pccard_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module pccard_cycle_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cfg_wait_mode = 0, cfg_readahead = 0;
  logic [3:0] cfg_fixed_len = 4'd3, cfg_min_strobe = 4'd1;
  logic req_valid = 0, req_ready, req_write = 0, req_incr = 0;
  logic [1:0] req_space = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [2:0] req_len = 0;
  logic rsp_valid, done, done_err, card_removed = 0;
  logic [15:0] rsp_data, card_addr, card_wdata, card_rdata;
  logic card_strobe, card_we, card_wait;
  logic [1:0] card_space;

  pccard_cycle_ctrl dut_i (.*);

  function automatic logic [15:0] fdat(input logic [1:0] s, input logic [15:0] a);
    return {s, a[13:0]} ^ 16'h5A3C;
  endfunction
  assign card_rdata = fdat(card_space, card_addr);

  int wait_hold = 0, scnt = 0;
  always @(posedge clk) scnt <= card_strobe ? scnt + 1 : 0;
  assign card_wait = card_strobe && (scnt < wait_hold);

  int n_tests = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  logic [15:0] exp_data[$];
  int exp_len[$], exp_tag_len = 0;
  string dtag = "R6", ltag = "R3";
  int cur_len = 0, rises = 0;
  logic [15:0] wr_data_seen, wr_addr_seen; logic [1:0] wr_space_seen;

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_data.size() == 0) check(0, {dtag, " unexpected word"}, rsp_data, 0);
      else begin automatic logic [15:0] e = exp_data.pop_front(); check(rsp_data == e, dtag, rsp_data, e); end
    end
    if (card_strobe) begin
      if (cur_len == 0) rises++;
      cur_len++;
      if (card_we) begin wr_data_seen = card_wdata; wr_addr_seen = card_addr; wr_space_seen = card_space; end
    end else if (cur_len > 0) begin
      if (exp_len.size() == 0) check(0, {ltag, " unexpected strobe"}, cur_len, 0);
      else begin automatic int e = exp_len.pop_front(); check(cur_len == e, ltag, cur_len, e); end
      cur_len = 0;
    end
  end

  task automatic do_req(input bit wr, input logic [1:0] sp, input logic [15:0] a, input logic [15:0] wd,
                        input int n, input bit inc, input int slen, input int nstr, input bit eerr, input string tag);
    automatic logic [1:0] spm = (sp == 2'd3) ? 2'd0 : sp;
    dtag = tag; ltag = tag;
    if (!wr && !eerr) for (int i = 0; i < n; i++) exp_data.push_back(fdat(spm, inc ? a + 16'(i) : a));
    for (int i = 0; i < nstr; i++) exp_len.push_back(slen);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_space = sp; req_addr = a; req_wdata = wd;
    req_len = 3'(n - 1); req_incr = inc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready || done, "R12 ready while busy", req_ready, 0);
    while (!done) @(negedge clk);
    check(done_err == eerr, {tag, " done_err"}, done_err, eerr);
    while (!req_ready || card_strobe) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++; $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    check(req_ready == 1 && card_strobe == 0 && card_space == 0 && !rsp_valid && !done, "R1 reset outputs", {req_ready, card_strobe, card_space}, 4'b1000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(req_ready == 1 && card_space == 0, "R1 after release", card_space, 0);

    do_req(0, 2'd0, 16'h0100, 0, 4, 1, 3, 4, 0, "R6 incr read common");
    do_req(0, 2'd1, 16'h0200, 0, 3, 0, 3, 3, 0, "R6 static read attr");
    do_req(0, 2'd2, 16'h0300, 0, 2, 1, 3, 2, 0, "R2 io read");
    do_req(0, 2'd3, 16'h0310, 0, 2, 1, 3, 2, 0, "R2 code3 as common");
    cfg_fixed_len = 4'd0;
    do_req(0, 2'd0, 16'h0320, 0, 2, 1, 2, 2, 0, "R3 min len 2");
    cfg_fixed_len = 4'd15;
    do_req(0, 2'd0, 16'h0330, 0, 1, 1, 15, 1, 0, "R3 len 15");
    cfg_fixed_len = 4'd3;

    do_req(1, 2'd2, 16'h0033, 16'hBEEF, 1, 1, 3, 1, 0, "R7 write");
    check(wr_data_seen == 16'hBEEF && wr_addr_seen == 16'h0033 && wr_space_seen == 2'd2, "R7 write bus", wr_data_seen, 16'hBEEF);

    cfg_wait_mode = 1; cfg_min_strobe = 4'd4; wait_hold = 1;
    do_req(0, 2'd0, 16'h0040, 0, 2, 1, 4, 2, 0, "R4 min dominates");
    cfg_min_strobe = 4'd2; wait_hold = 6;
    do_req(0, 2'd0, 16'h0050, 0, 2, 1, 7, 2, 0, "R4 wait dominates");
    cfg_min_strobe = 4'd0; wait_hold = 0;
    do_req(0, 2'd1, 16'h0060, 0, 1, 1, 1, 1, 0, "R4 min zero as one");
    wait_hold = 400;
    do_req(0, 2'd0, 16'h0070, 0, 1, 1, 255, 1, 1, "R5 timeout");
    cfg_wait_mode = 0; wait_hold = 0; cfg_fixed_len = 4'd2;

    cfg_readahead = 1;
    do_req(0, 2'd0, 16'h0400, 0, 8, 1, 2, 16, 0, "R8 read then prefetch");
    r0 = rises;
    do_req(0, 2'd0, 16'h0408, 0, 8, 1, 2, 0, 0, "R9 buffer hit 8");
    do_req(0, 2'd0, 16'h0408, 0, 3, 1, 2, 0, 0, "R9 buffer hit 3");
    check(rises == r0, "R9 no card cycle on hit", rises - r0, 0);
    do_req(0, 2'd0, 16'h0409, 0, 1, 1, 2, 1, 0, "R9 misaligned miss");

    do_req(1, 2'd0, 16'h0001, 16'h1234, 1, 1, 2, 1, 0, "R10 write");
    do_req(0, 2'd0, 16'h0408, 0, 1, 1, 2, 1, 0, "R10 miss after write");

    do_req(0, 2'd0, 16'h0400, 0, 8, 1, 2, 16, 0, "R8 refill");
    do_req(0, 2'd1, 16'h0010, 0, 1, 1, 2, 1, 0, "R10 space change");
    do_req(0, 2'd0, 16'h0408, 0, 1, 1, 2, 1, 0, "R10 miss after space change");

    do_req(0, 2'd0, 16'h0400, 0, 8, 1, 2, 16, 0, "R8 refill2");
    do_req(0, 2'd1, 16'h0011, 0, 1, 1, 2, 1, 0, "R11 attr access");
    check(card_space == 2'd1, "R11 space before removal", card_space, 1);
    @(negedge clk); card_removed = 1; @(negedge clk); card_removed = 0;
    check(card_space == 2'd0, "R11 space common after removal", card_space, 0);
    do_req(0, 2'd0, 16'h0500, 0, 8, 1, 2, 16, 0, "R8 refill3");
    @(negedge clk); card_removed = 1; @(negedge clk); card_removed = 0;
    do_req(0, 2'd0, 16'h0508, 0, 1, 1, 2, 1, 0, "R10 miss after removal");

    repeat (5) @(negedge clk);
    check(exp_data.size() == 0, "R6 data queue drained", exp_data.size(), 0);
    check(exp_len.size() == 0, "R3 strobe queue drained", exp_len.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule